// File: doc/BRIEF.md
# Serial Link Test Symbol Generator

This block sits in a multi-gigabit serial lane between the 8b/10b line encoder and the serializer. In normal operation it passes the encoded 10-bit symbols through unchanged. When a 3-bit select field picks a test mode, it replaces that stream with a link-quality pattern. Because the pattern is injected after the encoder, its symbols never go through the encoder.

The available patterns are:
- a steady high-frequency data pattern;
- an alternating comma pattern, which can also issue a periodic request to restart the lane alignment sequence;
- a fixed 12-symbol repeating jitter pattern;
- a pseudo-random bit sequence whose length is set by a separate 2-bit field.

One symbol leaves the block every clock, registered. Any change of the select field restarts the pattern that is being entered.

Top module: `link_test_symgen`

## Requirements
- R1: While reset (`rst_n` low) is applied, `sym_out` is 0 and `align_restart` is 0.
- R2: Select codes 0, 5 and 7 forward `enc_sym_in` to `sym_out` with one clock of latency.
- R3: Select code 1 outputs 10'b1010101010 (0x2AA) on every symbol.
- R4: Select code 2 outputs comma symbols that alternate between 0x0FA and 0x305. The first symbol after entering the code is 0x0FA.
- R5: Select code 3 outputs the same alternating comma symbols as code 2. It also pulses `align_restart` for exactly one clock on every RESTART_PERIOD-th output cycle spent in the code, counted from entry. The pulse appears alongside the symbol of that cycle.
- R6: `align_restart` is never high on an output cycle that did not come from select code 3. Leaving code 3 restarts its period count.
- R7: Select code 4 cycles through 12 symbols in this order: 0x3E8, 0x17C, 0x2AA, 0x0F5, 0x1A6, 0x355, 0x0CB, 0x2D4, 0x1F0, 0x30F, 0x25A, 0x1A5. The cycle starts at the first symbol on entry.
- R8: Select code 6 outputs a pseudo-random sequence, ten bits per clock, with the first generated bit in bit 9. `prbs_sel` chooses the length:
  - 0: feedback from bits 7 and 6;
  - 1: feedback from bits 15 and 14;
  - 2: feedback from bits 23 and 18;
  - 3: feedback from bits 31 and 28.
  Each generated bit is the XOR of the two tap bits. It is shifted in at the low end and is also the output bit.
- R9: Any change of `mode_sel` reseeds the pseudo-random register to all ones. The symbol of that same cycle already uses the seed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 3 | Test mode select code |
| prbs_sel | input | 2 | Pseudo-random length select |
| enc_sym_in | input | 10 | Encoded symbol from the line encoder |
| sym_out | output | 10 | Symbol to the serializer |
| align_restart | output | 1 | One-clock request to restart the lane alignment sequence |

## Verification
Two events can meet in the same cycle:
- the periodic alignment-restart pulse;
- a change of the select field, which resets the period count.

The bench first holds code 3 long enough to see two pulses, each checked together with its comma symbol. It then enters code 3 again, stays exactly one cycle short of a period, and leaves on the cycle where the pulse would have fired. The scoreboard expects no pulse on that cycle and expects a fresh comma phase in the new code.

// File: rtl/link_test_symgen.sv
module link_test_symgen #(
  parameter int RESTART_PERIOD = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] mode_sel,
  input  logic [1:0] prbs_sel,
  input  logic [9:0] enc_sym_in,
  output logic [9:0] sym_out,
  output logic       align_restart
);
  localparam int CNT_W = $clog2(RESTART_PERIOD + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RESTART_PERIOD - 1);
  localparam logic [9:0] HF_SYM = 10'h2AA;
  localparam logic [9:0] COMMA_N = 10'h0FA;
  localparam logic [9:0] COMMA_P = 10'h305;
  localparam logic [9:0] JIT_TAB [12] = '{10'h3E8, 10'h17C, 10'h2AA, 10'h0F5,
                                          10'h1A6, 10'h355, 10'h0CB, 10'h2D4,
                                          10'h1F0, 10'h30F, 10'h25A, 10'h1A5};

  logic [2:0]       mode_q;
  logic             kph_q, kph_d;
  logic [3:0]       idx_q, idx_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [30:0]      lfsr_q, lfsr_d;
  logic [9:0]       sym_d;
  logic             al_d;

  wire chg = (mode_sel != mode_q);

  function automatic logic [40:0] prbs_step10(input logic [30:0] s_in, input logic [1:0] sel);
    logic [30:0] s;
    logic [9:0]  o;
    logic        nb;
    s = s_in;
    o = '0;
    for (int i = 0; i < 10; i++) begin
      case (sel)
        2'd0:    nb = s[6]  ^ s[5];
        2'd1:    nb = s[14] ^ s[13];
        2'd2:    nb = s[22] ^ s[17];
        default: nb = s[30] ^ s[27];
      endcase
      s = {s[29:0], nb};
      o[9-i] = nb;
    end
    return {o, s};
  endfunction

  always_comb begin
    logic        k;
    logic [3:0]  ix;
    logic [CNT_W-1:0] c;
    logic [40:0] pr;
    kph_d  = kph_q;
    idx_d  = idx_q;
    cnt_d  = cnt_q;
    lfsr_d = lfsr_q;
    sym_d  = enc_sym_in;
    al_d   = 1'b0;
    k  = chg ? 1'b0 : kph_q;
    ix = chg ? 4'd0 : idx_q;
    c  = chg ? '0 : cnt_q;
    pr = prbs_step10(chg ? '1 : lfsr_q, prbs_sel);
    case (mode_sel)
      3'd1: sym_d = HF_SYM;
      3'd2, 3'd3: begin
        sym_d = k ? COMMA_P : COMMA_N;
        kph_d = ~k;
        if (mode_sel == 3'd3) begin
          al_d  = (c == CNT_LAST);
          cnt_d = al_d ? '0 : c + 1'b1;
        end
      end
      3'd4: begin
        sym_d = JIT_TAB[ix];
        idx_d = (ix == 4'd11) ? 4'd0 : ix + 4'd1;
      end
      3'd6: begin
        sym_d  = pr[40:31];
        lfsr_d = pr[30:0];
      end
      default: sym_d = enc_sym_in;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q        <= '0;
      kph_q         <= 1'b0;
      idx_q         <= '0;
      cnt_q         <= '0;
      lfsr_q        <= '1;
      sym_out       <= '0;
      align_restart <= 1'b0;
    end else begin
      mode_q        <= mode_sel;
      kph_q         <= kph_d;
      idx_q         <= idx_d;
      cnt_q         <= cnt_d;
      lfsr_q        <= lfsr_d;
      sym_out       <= sym_d;
      align_restart <= al_d;
    end
  end
endmodule

// File: rtl/link_test_symgen_chk.sv
module link_test_symgen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] mode_sel,
  input logic [9:0] enc_sym_in,
  input logic [9:0] sym_out,
  input logic       align_restart
);
  // R2
  fwd_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && ($past(mode_sel) == 3'd0)) |-> (sym_out == $past(enc_sym_in)));

  // R3
  hf_pattern_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && ($past(mode_sel) == 3'd1)) |-> (sym_out == 10'h2AA));

  // R4
  comma_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(rst_n, 2) && ($past(mode_sel) == 3'd2) && ($past(mode_sel, 2) == 3'd2))
      |-> ((sym_out != $past(sym_out)) && ((sym_out == 10'h0FA) || (sym_out == 10'h305))));

  // R6
  restart_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    align_restart |-> ($past(rst_n) && ($past(mode_sel) == 3'd3)));

  // R5
  restart_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    align_restart |=> !align_restart);

  // R1
  always @(posedge clk)
    if (!rst_n && $past(!rst_n)) begin
      reset_out_chk: assert (sym_out == '0 && !align_restart);
    end
endmodule

bind link_test_symgen link_test_symgen_chk i_chk (
  .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .enc_sym_in(enc_sym_in),
  .sym_out(sym_out), .align_restart(align_restart)
);

// File: tb/test_link_test_symgen.sv
`timescale 1ns/1ps
module test_link_test_symgen;
  localparam int PER = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] mode_sel = '0;
  logic [1:0] prbs_sel = '0;
  logic [9:0] enc_sym_in = '0;
  logic [9:0] sym_out;
  logic       align_restart;

  link_test_symgen #(.RESTART_PERIOD(PER)) i_link_test_symgen (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .prbs_sel(prbs_sel),
    .enc_sym_in(enc_sym_in), .sym_out(sym_out), .align_restart(align_restart)
  );

  always #2.5 clk = ~clk;

  typedef struct { logic [9:0] sym; logic al; string tag; } item_t;
  item_t exp_q[$];

  int checks = 0, errors = 0;
  bit done = 0;

  logic [9:0] tab [12] = '{10'h3E8, 10'h17C, 10'h2AA, 10'h0F5, 10'h1A6, 10'h355,
                           10'h0CB, 10'h2D4, 10'h1F0, 10'h30F, 10'h25A, 10'h1A5};
  logic [2:0]  m_prev = '0;
  logic        m_kph = 0;
  int          m_idx = 0, m_cnt = 0;
  logic [30:0] m_lf = '1;

  task automatic step(input logic [2:0] m, input logic [1:0] ps, input logic [9:0] e, input string tag);
    item_t it;
    bit chg;
    int n, t;
    logic [30:0] s;
    logic nb;
    @(negedge clk);
    mode_sel = m; prbs_sel = ps; enc_sym_in = e;
    chg = (m != m_prev);
    it.sym = e; it.al = 0; it.tag = tag;
    if (m == 1) it.sym = 10'h2AA;
    else if (m == 2 || m == 3) begin
      if (chg) m_kph = 0;
      it.sym = m_kph ? 10'h305 : 10'h0FA;
      m_kph = ~m_kph;
      if (m == 3) begin
        if (chg) m_cnt = 0;
        m_cnt++;
        if (m_cnt == PER) begin it.al = 1; m_cnt = 0; end
      end
    end else if (m == 4) begin
      if (chg) m_idx = 0;
      it.sym = tab[m_idx];
      m_idx = (m_idx + 1) % 12;
    end else if (m == 6) begin
      case (ps) 0: begin n = 7; t = 6; end 1: begin n = 15; t = 14; end
                2: begin n = 23; t = 18; end default: begin n = 31; t = 28; end endcase
      s = chg ? '1 : m_lf;
      for (int i = 0; i < 10; i++) begin
        nb = s[n-1] ^ s[t-1];
        s = {s[29:0], nb};
        it.sym[9-i] = nb;
      end
      m_lf = s;
    end
    m_prev = m;
    exp_q.push_back(it);
  endtask

  initial begin
    forever begin
      @(posedge clk); #1;
      if (exp_q.size() > 0) begin
        item_t it;
        it = exp_q.pop_front();
        checks++;
        if (sym_out !== it.sym || align_restart !== it.al) begin
          errors++;
          $display("FAIL %s: sym=%h al=%b expected sym=%h al=%b", it.tag, sym_out, align_restart, it.sym, it.al);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 200000);
    checks++; errors++;
    $display("FAIL watchdog: run hung, expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    mode_sel = 3'd4; enc_sym_in = 10'h3FF;
    @(negedge clk);
    checks++;
    if (sym_out !== '0 || align_restart !== 1'b0) begin
      errors++;
      $display("FAIL R1: sym=%h al=%b expected sym=000 al=0", sym_out, align_restart);
    end
    mode_sel = 3'd0;
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 12; i++) step(3'd0, 2'd0, 10'((i * 97 + 5) & 10'h3FF), "R2");
    for (int i = 0; i < 5; i++)  step(3'd1, 2'd0, 10'h155, "R3");
    for (int i = 0; i < 5; i++)  step(3'd5, 2'd0, 10'(i * 31), "R2");
    for (int i = 0; i < 8; i++)  step(3'd2, 2'd0, 10'h000, "R4");
    for (int i = 0; i < 2 * PER + 3; i++) step(3'd3, 2'd0, 10'h000, "R5");
    for (int i = 0; i < 30; i++) step(3'd4, 2'd0, 10'h000, "R7");
    for (int p = 0; p < 4; p++) begin
      step(3'd0, 2'(p), 10'h0AA, "R2");
      for (int i = 0; i < 20; i++) step(3'd6, 2'(p), 10'h000, "R8");
    end
    step(3'd4, 2'd3, 10'h000, "R9");
    step(3'd6, 2'd3, 10'h000, "R9");
    step(3'd6, 2'd3, 10'h000, "R9");
    for (int i = 0; i < 5; i++) step(3'd7, 2'd0, 10'(i * 7 + 1), "R2");
    for (int i = 0; i < PER - 1; i++) step(3'd3, 2'd0, 10'h000, "R5");
    for (int i = 0; i < 4; i++) step(3'd2, 2'd0, 10'h000, "R6");
    for (int i = 0; i < PER + 1; i++) step(3'd3, 2'd0, 10'h000, "R5");
    step(3'd0, 2'd0, 10'h123, "R6");
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule